// File: doc/BRIEF.md
# Twin-Predicated Move Sequencer

This block drives a vectorised register-to-register move, or an element load, in which the source and the destination each carry their own predicate mask and their own scalar/vector tag. After a one-cycle start request, it walks a source index and a destination index. Each index independently skips the positions whose mask bit is clear. On each cycle it emits one copy pair that names the source element and the destination element as a register number plus an element offset within that register. The mix of tags and masks gives several behaviours. A scalar source with a vector destination broadcasts one value. A vector source with a scalar destination extracts one element. Two vector operands give a compacting copy, a gather-like copy or a scatter-like copy, and a sparse copy when both sides share one mask.

In load mode the source operand is the address register. A scalar address register produces unit-stride addresses that grow by the element size in bytes. A vector address register marks each pair as indirect, and the named source element then holds that element's address. The element read back from the register file or memory is returned on `rd_elem`. The block returns it on `wr_data` in the same cycle, sign- or zero-extended when the destination is scalar. The block holds neither the register file nor the memory.

Top module: `mvseq_twin_move`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid`, `busy`, `done` and `exc` are 0 until a start is accepted.
- R2: When an operand is tagged vector, its index starts at 0 and moves past every position whose mask bit is 0 before a pair is emitted. After each pair, every vector-tagged index advances by one. Pairs come out in increasing index order.
- R3: The length is clamped to MAXVL. The run ends with a one-cycle `done` pulse as soon as either index, after skipping, is not below the length. No partial pair is emitted, so a length of 0 or an empty vector mask gives no pair.
- R4: A scalar-tagged source stays on element 0 of `src_base` for every pair. With a vector destination, every enabled destination element receives that same source element.
- R5: A scalar-tagged destination receives exactly one pair, at element 0 of `dst_base`, and `done` is raised in the same cycle as that pair.
- R6: When both operands are vectors and share one mask, each pair has equal source and destination element indices, and only the enabled positions appear.
- R7: The element width code `elw` selects the element size: 0 means XLEN bits, 1 means 8 bits, 2 means 16 bits and 3 means 32 bits. Element index k of an operand maps to register base + k / (XLEN/size) and to offset k mod (XLEN/size).
- R8: In load mode with a scalar address operand, pair n carries `ld_addr` = `addr_base` + n times the element size in bytes, and `ld_indirect` = 0. With a vector address operand, `ld_indirect` = 1.
- R9: With a scalar destination, `wr_data` is `rd_elem` cut to the element size and sign-extended to XLEN, or zero-extended when `zext` = 1. With a vector destination, `wr_data` is the element's low bits with the upper bits cleared.
- R10: If a step would map either element to a register number of NREGS or more, no pair is emitted, and `exc` and `done` are raised together for one cycle.
- R11: A start request while `busy` = 1 is ignored: the running sequence goes on with its original settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, taken when idle |
| vl | input | IW | Vector length, clamped to MAXVL |
| src_vec | input | 1 | Source is tagged vector |
| dst_vec | input | 1 | Destination is tagged vector |
| src_mask | input | MAXVL | Source predicate mask |
| dst_mask | input | MAXVL | Destination predicate mask |
| src_base | input | RW | Source base register |
| dst_base | input | RW | Destination base register |
| elw | input | 2 | Element width code |
| ld_mode | input | 1 | Source operand is a load address register |
| zext | input | 1 | Zero-extend instead of sign-extend into a scalar |
| addr_base | input | AW | Base address for unit-stride loads |
| rd_elem | input | XLEN | Element data returned for the current pair |
| out_valid | output | 1 | A copy pair is presented |
| src_reg | output | RW | Source register of the pair |
| src_off | output | OW | Source element offset in that register |
| dst_reg | output | RW | Destination register of the pair |
| dst_off | output | OW | Destination element offset in that register |
| ld_addr | output | AW | Unit-stride load address of the pair |
| ld_indirect | output | 1 | Address is held in the source element |
| wr_data | output | XLEN | Extended write data for the destination |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle end-of-sequence pulse |
| exc | output | 1 | Register range exception, with done |

## Verification
The assertions check on every cycle the rules that hold whatever the masks are. The position scanned on a vector source must be enabled, `done` lasts one cycle, and an exception never comes with a pair. A scalar destination finishes on its only pair, unit-stride addresses step by the element size, and the latched settings stay still while a run is active. Only the bench's scenarios can show that the complete pair lists for twin masks, broadcast, extract, sparse copy, register overrun and length clamping come out in the right order, and that the extension and address values are correct.

// File: rtl/mvseq_pkg.sv
package mvseq_pkg;

  typedef enum logic {MV_IDLE, MV_RUN} mv_state_e;

  localparam logic [1:0] EW_FULL = 2'd0;
  localparam logic [1:0] EW_B    = 2'd1;
  localparam logic [1:0] EW_H    = 2'd2;
  localparam logic [1:0] EW_W    = 2'd3;

  // log2 of the number of elements held by one register
  function automatic logic [3:0] ew_elem_shift(input logic [1:0] ew, input int unsigned xlen);
    int unsigned lx;
    lx = $clog2(xlen);
    unique case (ew)
      EW_B:    return 4'(lx - 3);
      EW_H:    return 4'(lx - 4);
      EW_W:    return 4'(lx - 5);
      default: return 4'd0;
    endcase
  endfunction

  // log2 of the element size in bytes
  function automatic logic [3:0] ew_byte_shift(input logic [1:0] ew, input int unsigned xlen);
    unique case (ew)
      EW_B:    return 4'd0;
      EW_H:    return 4'd1;
      EW_W:    return 4'd2;
      default: return 4'($clog2(xlen) - 3);
    endcase
  endfunction

endpackage

// File: rtl/mvseq_pred_scan.sv
module mvseq_pred_scan #(
  parameter int MAXVL = 16,
  parameter int IW    = 5
) (
  input  logic [MAXVL-1:0] mask,
  input  logic [IW-1:0]    from,
  input  logic             use_mask,
  output logic [IW-1:0]    pos
);
  // Lowest enabled position at or above 'from'; MAXVL when none.
  always_comb begin
    if (!use_mask) begin
      pos = from;
    end else begin
      pos = IW'(MAXVL);
      for (int k = MAXVL - 1; k >= 0; k--) begin
        if ((IW'(k) >= from) && mask[k]) pos = IW'(k);
      end
    end
  end
endmodule

// File: rtl/mvseq_elem_map.sv
module mvseq_elem_map
  import mvseq_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int NREGS = 32,
  parameter int IW    = 5,
  parameter int RW    = 5,
  parameter int OW    = 3
) (
  input  logic [RW-1:0] base,
  input  logic [IW-1:0] idx,
  input  logic [1:0]    ew,
  output logic [RW-1:0] reg_o,
  output logic [OW-1:0] off_o,
  output logic          oob
);
  localparam int SW = RW + IW + 1;

  logic [3:0]    sh;
  logic [IW-1:0] hi;
  logic [IW-1:0] lo_mask;
  logic [SW-1:0] sum;

  always_comb begin
    sh      = ew_elem_shift(ew, XLEN);
    hi      = idx >> sh;
    lo_mask = (IW'(1) << sh) - IW'(1);
    sum     = SW'(base) + SW'(hi);
    oob     = sum >= SW'(NREGS);
    reg_o   = sum[RW-1:0];
    off_o   = OW'(idx & lo_mask);
  end
endmodule

// File: rtl/mvseq_extend.sv
module mvseq_extend
  import mvseq_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] din,
  input  logic [1:0]      ew,
  input  logic            to_scalar,
  input  logic            zext,
  output logic [XLEN-1:0] dout
);
  logic [XLEN-1:0] msk;
  logic [XLEN-1:0] lo;
  logic            sgn;

  always_comb begin
    msk = '1;
    sgn = 1'b0;
    unique case (ew)
      EW_B:    begin msk = XLEN'({8{1'b1}});  sgn = din[7];  end
      EW_H:    begin msk = XLEN'({16{1'b1}}); sgn = din[15]; end
      EW_W:    begin msk = XLEN'({32{1'b1}}); sgn = din[31]; end
      default: ;
    endcase
    lo   = din & msk;
    dout = (to_scalar && !zext && sgn) ? (lo | ~msk) : lo;
  end
endmodule

// File: rtl/mvseq_twin_move.sv
module mvseq_twin_move
  import mvseq_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int NREGS = 32,
  parameter int MAXVL = 16,
  parameter int AW    = 32,
  localparam int IW   = $clog2(MAXVL + 1),
  localparam int RW   = $clog2(NREGS),
  localparam int OW   = $clog2(XLEN / 8)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IW-1:0]    vl,
  input  logic             src_vec,
  input  logic             dst_vec,
  input  logic [MAXVL-1:0] src_mask,
  input  logic [MAXVL-1:0] dst_mask,
  input  logic [RW-1:0]    src_base,
  input  logic [RW-1:0]    dst_base,
  input  logic [1:0]       elw,
  input  logic             ld_mode,
  input  logic             zext,
  input  logic [AW-1:0]    addr_base,
  input  logic [XLEN-1:0]  rd_elem,
  output logic             out_valid,
  output logic [RW-1:0]    src_reg,
  output logic [OW-1:0]    src_off,
  output logic [RW-1:0]    dst_reg,
  output logic [OW-1:0]    dst_off,
  output logic [AW-1:0]    ld_addr,
  output logic             ld_indirect,
  output logic [XLEN-1:0]  wr_data,
  output logic             busy,
  output logic             done,
  output logic             exc
);

  // ---------------- state and latched settings ----------------
  mv_state_e        st_q, st_d;
  logic [IW-1:0]    i_q, i_d, j_q, j_d, n_q, n_d;
  logic             done_d, exc_d, ov_d;

  logic [IW-1:0]    cfg_vl;
  logic             cfg_sv, cfg_dv, cfg_ld, cfg_zx;
  logic [MAXVL-1:0] cfg_sm, cfg_dm;
  logic [RW-1:0]    cfg_sb, cfg_db;
  logic [1:0]       cfg_ew;
  logic [AW-1:0]    cfg_ab;

  logic             cfg_en, emit;
  logic [IW-1:0]    vl_clamp;

  // ---------------- index scan and element mapping ----------------
  logic [IW-1:0]    si, dj;
  logic [RW-1:0]    s_reg, d_reg;
  logic [OW-1:0]    s_off, d_off;
  logic             s_oob, d_oob;
  logic [3:0]       bsh;
  logic [AW-1:0]    addr_now;

  mvseq_pred_scan #(.MAXVL(MAXVL), .IW(IW)) u_scan_src (
    .mask(cfg_sm), .from(i_q), .use_mask(cfg_sv), .pos(si)
  );

  mvseq_pred_scan #(.MAXVL(MAXVL), .IW(IW)) u_scan_dst (
    .mask(cfg_dm), .from(j_q), .use_mask(cfg_dv), .pos(dj)
  );

  mvseq_elem_map #(.XLEN(XLEN), .NREGS(NREGS), .IW(IW), .RW(RW), .OW(OW)) u_map_src (
    .base(cfg_sb), .idx(si), .ew(cfg_ew), .reg_o(s_reg), .off_o(s_off), .oob(s_oob)
  );

  mvseq_elem_map #(.XLEN(XLEN), .NREGS(NREGS), .IW(IW), .RW(RW), .OW(OW)) u_map_dst (
    .base(cfg_db), .idx(dj), .ew(cfg_ew), .reg_o(d_reg), .off_o(d_off), .oob(d_oob)
  );

  mvseq_extend #(.XLEN(XLEN)) u_ext (
    .din(rd_elem), .ew(cfg_ew), .to_scalar(!cfg_dv), .zext(cfg_zx), .dout(wr_data)
  );

  // ---------------- next-state logic ----------------
  always_comb begin
    vl_clamp = (vl > IW'(MAXVL)) ? IW'(MAXVL) : vl;
    bsh      = ew_byte_shift(cfg_ew, XLEN);
    addr_now = cfg_ab + (AW'(n_q) << bsh);
    cfg_en   = (st_q == MV_IDLE) && start;

    st_d   = st_q;
    i_d    = i_q;
    j_d    = j_q;
    n_d    = n_q;
    ov_d   = 1'b0;
    done_d = 1'b0;
    exc_d  = 1'b0;
    emit   = 1'b0;

    unique case (st_q)
      MV_IDLE: begin
        if (start) begin
          st_d = MV_RUN;
          i_d  = '0;
          j_d  = '0;
          n_d  = '0;
        end
      end
      MV_RUN: begin
        if ((si >= cfg_vl) || (dj >= cfg_vl)) begin
          st_d   = MV_IDLE;
          done_d = 1'b1;
        end else if (s_oob || d_oob) begin
          st_d   = MV_IDLE;
          done_d = 1'b1;
          exc_d  = 1'b1;
        end else begin
          emit = 1'b1;
          ov_d = 1'b1;
          i_d  = cfg_sv ? si + IW'(1) : si;
          j_d  = cfg_dv ? dj + IW'(1) : dj;
          n_d  = n_q + IW'(1);
          if (!cfg_dv) begin
            st_d   = MV_IDLE;
            done_d = 1'b1;
          end
        end
      end
      default: st_d = MV_IDLE;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= MV_IDLE;
      i_q       <= '0;
      j_q       <= '0;
      n_q       <= '0;
      out_valid <= 1'b0;
      done      <= 1'b0;
      exc       <= 1'b0;
    end else begin
      st_q      <= st_d;
      i_q       <= i_d;
      j_q       <= j_d;
      n_q       <= n_d;
      out_valid <= ov_d;
      done      <= done_d;
      exc       <= exc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_vl <= '0;
      cfg_sv <= 1'b0;
      cfg_dv <= 1'b0;
      cfg_ld <= 1'b0;
      cfg_zx <= 1'b0;
      cfg_sm <= '0;
      cfg_dm <= '0;
      cfg_sb <= '0;
      cfg_db <= '0;
      cfg_ew <= EW_FULL;
      cfg_ab <= '0;
    end else if (cfg_en) begin
      cfg_vl <= vl_clamp;
      cfg_sv <= src_vec;
      cfg_dv <= dst_vec;
      cfg_ld <= ld_mode;
      cfg_zx <= zext;
      cfg_sm <= src_mask;
      cfg_dm <= dst_mask;
      cfg_sb <= src_base;
      cfg_db <= dst_base;
      cfg_ew <= elw;
      cfg_ab <= addr_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_reg     <= '0;
      src_off     <= '0;
      dst_reg     <= '0;
      dst_off     <= '0;
      ld_addr     <= '0;
      ld_indirect <= 1'b0;
    end else if (emit) begin
      src_reg     <= s_reg;
      src_off     <= s_off;
      dst_reg     <= d_reg;
      dst_off     <= d_off;
      ld_addr     <= addr_now;
      ld_indirect <= cfg_ld && cfg_sv;
    end
  end

  assign busy = (st_q == MV_RUN);

  // ---------------- assertions ----------------
  assert_src_scan_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_sv && (si < cfg_vl)) |-> (((cfg_sm >> si) & MAXVL'(1)) != '0));

  assert_done_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_scalar_dst_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !cfg_dv) |-> done);

  assert_unit_stride_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid) && cfg_ld && !cfg_sv)
      |-> (ld_addr == $past(ld_addr) + (AW'(1) << bsh)));

  assert_exc_no_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
    exc |-> (done && !out_valid));

  assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(cfg_vl) && $stable(cfg_sm) && $stable(cfg_dm)
                               && $stable(cfg_sv) && $stable(cfg_dv)));

endmodule

// File: tb/test_mvseq_twin_move.sv
`timescale 1ns/1ps
module test_mvseq_twin_move;

  localparam int XLEN = 64, NREGS = 32, MAXVL = 16, AW = 32;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [4:0]  vl = '0;
  logic        src_vec = 0, dst_vec = 0, ld_mode = 0, zext = 0;
  logic [15:0] src_mask = '0, dst_mask = '0;
  logic [4:0]  src_base = '0, dst_base = '0;
  logic [1:0]  elw = '0;
  logic [31:0] addr_base = '0;
  logic [63:0] rd_elem = '0;
  logic        out_valid, ld_indirect, busy, done, exc;
  logic [4:0]  src_reg, dst_reg;
  logic [2:0]  src_off, dst_off;
  logic [31:0] ld_addr;
  logic [63:0] wr_data;

  always #4 clk = ~clk;

  mvseq_twin_move #(.XLEN(XLEN), .NREGS(NREGS), .MAXVL(MAXVL), .AW(AW)) i_mvseq_twin_move (
    .clk, .rst_n, .start, .vl, .src_vec, .dst_vec, .src_mask, .dst_mask, .src_base, .dst_base,
    .elw, .ld_mode, .zext, .addr_base, .rd_elem, .out_valid, .src_reg, .src_off, .dst_reg,
    .dst_off, .ld_addr, .ld_indirect, .wr_data, .busy, .done, .exc
  );

  typedef struct packed {
    logic [4:0]  vl;
    logic        sv, dv;
    logic [15:0] sm, dm;
    logic [4:0]  sb, db;
    logic [1:0]  ew;
    logic        ld, zx;
    logic [31:0] ab;
    logic [63:0] rd;
    int          np;
    logic        ex;
  } vec_t;

  localparam logic [63:0] RDV = 64'h0123_4567_89AB_CDF0;
  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{5'd8,  1'b1, 1'b1, 16'hFFFF, 16'hFFFF, 5'd0,  5'd8,  2'd0, 1'b0, 1'b0, 32'h0,    RDV, 8,  1'b0},
    '{5'd10, 1'b1, 1'b1, 16'h0155, 16'h00F0, 5'd2,  5'd4,  2'd0, 1'b0, 1'b0, 32'h0,    RDV, 4,  1'b0},
    '{5'd8,  1'b0, 1'b1, 16'h0000, 16'h00A5, 5'd5,  5'd10, 2'd0, 1'b0, 1'b0, 32'h0,    RDV, 4,  1'b0},
    '{5'd8,  1'b1, 1'b0, 16'h0030, 16'h0000, 5'd1,  5'd9,  2'd0, 1'b0, 1'b0, 32'h0,    RDV, 1,  1'b0},
    '{5'd12, 1'b1, 1'b1, 16'h03C3, 16'h03C3, 5'd0,  5'd16, 2'd0, 1'b0, 1'b0, 32'h0,    RDV, 6,  1'b0},
    '{5'd16, 1'b1, 1'b1, 16'hFFFF, 16'hFFFF, 5'd3,  5'd31, 2'd1, 1'b0, 1'b0, 32'h0,    RDV, 8,  1'b1},
    '{5'd4,  1'b0, 1'b1, 16'h0000, 16'h000F, 5'd7,  5'd0,  2'd2, 1'b1, 1'b0, 32'h1000, RDV, 4,  1'b0},
    '{5'd8,  1'b1, 1'b1, 16'h00AA, 16'hFFFF, 5'd6,  5'd12, 2'd3, 1'b1, 1'b0, 32'h2000, RDV, 4,  1'b0},
    '{5'd0,  1'b1, 1'b1, 16'hFFFF, 16'hFFFF, 5'd0,  5'd0,  2'd0, 1'b0, 1'b0, 32'h0,    RDV, 0,  1'b0},
    '{5'd8,  1'b1, 1'b1, 16'h0000, 16'hFFFF, 5'd0,  5'd0,  2'd0, 1'b0, 1'b0, 32'h0,    RDV, 0,  1'b0},
    '{5'd8,  1'b1, 1'b0, 16'h0004, 16'h0000, 5'd2,  5'd3,  2'd1, 1'b0, 1'b0, 32'h0,    RDV, 1,  1'b0},
    '{5'd8,  1'b1, 1'b0, 16'h0004, 16'h0000, 5'd2,  5'd3,  2'd1, 1'b0, 1'b1, 32'h0,    RDV, 1,  1'b0},
    '{5'd20, 1'b1, 1'b1, 16'hFFFF, 16'hFFFF, 5'd0,  5'd0,  2'd0, 1'b0, 1'b0, 32'h0,    RDV, 16, 1'b0},
    '{5'd4,  1'b1, 1'b1, 16'hFFFF, 16'hFFFF, 5'd30, 5'd0,  2'd0, 1'b0, 1'b0, 32'h0,    RDV, 2,  1'b1}
  };

  int nchk = 0, nerr = 0;

  // observed and expected pair lists
  int g_n, e_n;
  logic g_exc, e_exc;
  logic [4:0]  g_sr[32], g_dr[32], e_sr[32], e_dr[32];
  logic [2:0]  g_so[32], g_do[32], e_so[32], e_do[32];
  logic [31:0] g_ad[32], e_ad[32];
  logic        g_in[32], e_in[32];
  logic [63:0] g_wd[32], e_wd[32];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int k);
    case (k)
      0, 1:      return "R2";
      2:         return "R4";
      3:         return "R5";
      4:         return "R6";
      5, 13:     return "R10";
      6, 7:      return "R8";
      10, 11:    return "R9";
      default:   return "R3";
    endcase
  endfunction

  function automatic int elem_sh(input logic [1:0] ew);
    case (ew) 2'd1: return 3; 2'd2: return 2; 2'd3: return 1; default: return 0; endcase
  endfunction

  function automatic int elem_bytes(input logic [1:0] ew);
    case (ew) 2'd1: return 1; 2'd2: return 2; 2'd3: return 4; default: return 8; endcase
  endfunction

  function automatic logic [63:0] ext_of(input vec_t v);
    int b;
    logic [63:0] m, lo;
    b  = elem_bytes(v.ew) * 8;
    m  = (b == 64) ? '1 : ((64'd1 << b) - 64'd1);
    lo = v.rd & m;
    if (!v.dv && !v.zx && b < 64 && v.rd[b-1]) lo = lo | ~m;
    return lo;
  endfunction

  // reference from the requirements
  task automatic model(input vec_t v);
    int i = 0, j = 0, n = 0, vlc, sh, sr, dr;
    vlc = (v.vl > 16) ? 16 : int'(v.vl);
    sh = elem_sh(v.ew);
    e_n = 0; e_exc = 0;
    forever begin
      if (v.sv) while (i < vlc && !v.sm[i]) i++;
      if (v.dv) while (j < vlc && !v.dm[j]) j++;
      if (i >= vlc || j >= vlc) break;
      sr = int'(v.sb) + (i >> sh);
      dr = int'(v.db) + (j >> sh);
      if (sr >= NREGS || dr >= NREGS) begin e_exc = 1; break; end
      e_sr[e_n] = 5'(sr); e_so[e_n] = 3'(i & ((1 << sh) - 1));
      e_dr[e_n] = 5'(dr); e_do[e_n] = 3'(j & ((1 << sh) - 1));
      e_ad[e_n] = v.ab + 32'(n * elem_bytes(v.ew));
      e_in[e_n] = v.ld && v.sv;
      e_wd[e_n] = ext_of(v);
      e_n++;
      if (v.sv) i++;
      if (v.dv) j++;
      n++;
      if (!v.dv) break;
    end
  endtask

  task automatic run(input vec_t v, input bit poke);
    int cyc = 0;
    @(negedge clk);
    vl = v.vl; src_vec = v.sv; dst_vec = v.dv; src_mask = v.sm; dst_mask = v.dm;
    src_base = v.sb; dst_base = v.db; elw = v.ew; ld_mode = v.ld; zext = v.zx;
    addr_base = v.ab; rd_elem = v.rd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    g_n = 0; g_exc = 0;
    forever begin
      if (poke && cyc == 2) begin start = 1'b1; vl = 5'd1; src_mask = '0; dst_vec = 1'b0; end
      if (poke && cyc == 3) start = 1'b0;
      if (out_valid && g_n < 32) begin
        g_sr[g_n] = src_reg; g_so[g_n] = src_off; g_dr[g_n] = dst_reg; g_do[g_n] = dst_off;
        g_ad[g_n] = ld_addr; g_in[g_n] = ld_indirect; g_wd[g_n] = wr_data;
        g_n++;
      end
      if (done) begin g_exc = exc; break; end
      cyc++;
      if (cyc > 300) begin check(0, "R3", "run watchdog", 64'(cyc), 64'd0); break; end
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic compare(input vec_t v, input string req);
    model(v);
    check(g_n == v.np, req, "pair count vs table", 64'(g_n), 64'(v.np));
    check(g_n == e_n, req, "pair count vs model", 64'(g_n), 64'(e_n));
    check(g_exc == v.ex, "R10", "exception flag", 64'(g_exc), 64'(v.ex));
    for (int k = 0; k < e_n && k < g_n; k++) begin
      check(g_sr[k] == e_sr[k] && g_so[k] == e_so[k], "R7", "source element",
            {g_sr[k], g_so[k]}, {e_sr[k], e_so[k]});
      check(g_dr[k] == e_dr[k] && g_do[k] == e_do[k], "R7", "destination element",
            {g_dr[k], g_do[k]}, {e_dr[k], e_do[k]});
      check(g_in[k] == e_in[k], "R8", "indirect flag", 64'(g_in[k]), 64'(e_in[k]));
      if (v.ld && !v.sv) check(g_ad[k] == e_ad[k], "R8", "stride address", 64'(g_ad[k]), 64'(e_ad[k]));
      check(g_wd[k] == e_wd[k], "R9", "write data", g_wd[k], e_wd[k]);
    end
  endtask

  initial begin
    #(8 * 200000);
    check(0, "R3", "global watchdog", 64'd0, 64'd1);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: idle outputs during and after reset
    check(!out_valid && !busy && !done && !exc, "R1", "outputs in reset",
          {out_valid, busy, done, exc}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!out_valid && !busy && !done && !exc, "R1", "outputs after reset",
          {out_valid, busy, done, exc}, 64'd0);

    for (int t = 0; t < NV; t++) begin
      run(TBL[t], 1'b0);
      compare(TBL[t], tag_of(t));
    end

    // R6: sparse copy keeps positions aligned
    run(TBL[4], 1'b0);
    for (int k = 0; k < g_n; k++)
      check(g_so[k] == g_do[k] && g_sr[k] - 5'd0 == g_dr[k] - 5'd16, "R6", "aligned positions",
            {g_sr[k], g_so[k]}, {g_dr[k] - 5'd16, g_do[k]});

    // R4: broadcast source fixed at element 0 of its base
    run(TBL[2], 1'b0);
    for (int k = 0; k < g_n; k++)
      check(g_sr[k] == 5'd5 && g_so[k] == 3'd0, "R4", "broadcast source", {g_sr[k], g_so[k]}, {5'd5, 3'd0});

    // R11: start while busy is ignored
    run(TBL[12], 1'b1);
    compare(TBL[12], "R11");

    @(negedge clk);
    check(!busy && !out_valid, "R3", "idle after run", {busy, out_valid}, 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule